// File: doc/BRIEF.md
# Bookmark-and-Replay FIFO

A single-clock first-in first-out buffer that can bookmark a point in its read stream and later replay the data from that point. Words are written through a write port with an enable and read through a registered read port with an enable. Empty and full flags report the buffer's state.

Holding the `mark_hold` input high starts replay mode. On the first clock edge where it is sampled high, the block stores the current read address as the bookmark. While it stays high, reads and writes continue. The write pointer may not advance past the bookmarked entry, so every word from the bookmark onward stays intact. A pulse on `rewind` sets the read pointer back to the bookmark, and the data is then read out again. Sampling `mark_hold` low ends replay mode and releases the protected region. Raising it again sets a new bookmark, and only the newest bookmark has any effect.

Top module: `mark_rexmit_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `replay_mode` is 0 and `rd_data` is all zeros.
- R2: Accepted writes are returned in write order. A read is accepted when `rd_en` is 1 and `empty` is 0, and its word appears on `rd_data` right after that clock edge.
- R3: A write attempted while `full` is 1 is discarded. No pointer moves, and the discarded word never appears on `rd_data`.
- R4: A read attempted while `empty` is 1 has no effect, and `rd_data` keeps its previous value.
- R5: On a clock edge where `mark_hold` is 1 and `replay_mode` is 0, `replay_mode` becomes 1. The bookmark takes the read address that was current before any read accepted on that same edge.
- R6: `replay_mode` stays 1 for as long as `mark_hold` is sampled 1. The first edge with `mark_hold` at 0 clears it. A later rise of `mark_hold` replaces the bookmark with the read address current at that time.
- R7: In replay mode, `full` is 1 once the write pointer is DEPTH entries ahead of the bookmark, even when fewer than DEPTH words are unread.
- R8: In replay mode, a `rewind` pulse reloads the read pointer from the bookmark. The following reads return the words again, starting at the bookmarked word, and `empty` reflects the restored occupancy. A read requested on the same edge as the rewind is not performed.
- R9: `rewind` has no effect while `replay_mode` is 0.
- R10: Once replay mode ends, `full` depends only on the unread occupancy reaching DEPTH.
- R11: In replay mode, writes are accepted normally until the limit in R7 is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered read word |
| mark_hold | input | 1 | Level that sets the bookmark and holds replay mode |
| rewind | input | 1 | Return the read pointer to the bookmark |
| empty | output | 1 | No unread word |
| full | output | 1 | No write can be accepted |
| replay_mode | output | 1 | Bookmark active |

## Verification
The assertions assume that every input is a known 0 or 1 at each clock edge once reset is released. They also assume that reset is applied before the first use of the block. Beyond that, requests during empty, full or normal mode are legal, and the assertions expect them to be ignored rather than excluded. The stimulus changes inputs only on the falling clock edge. It holds `mark_hold` for runs of random length, so the block moves in and out of replay mode many times. It issues `rewind` both inside and outside replay mode, and it pushes writes against both kinds of full condition.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
   typedef enum logic {
      MODE_NORMAL = 1'b0,
      MODE_REPLAY = 1'b1
   } fifo_mode_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/mrf_mark_ctrl.sv
module mrf_mark_ctrl
   import fifo_rt_pkg::*;
#(
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mark_hold,
   input  logic          rewind,
   input  logic [PW-1:0] rd_ptr,
   output fifo_mode_e    mode,
   output logic [PW-1:0] mark_ptr,
   output logic          reload
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= MODE_NORMAL;
         mark_ptr <= '0;
      end else if (!mark_hold) begin
         mode <= MODE_NORMAL;
      end else if (mode == MODE_NORMAL) begin
         mode     <= MODE_REPLAY;
         mark_ptr <= rd_ptr;
      end
   end

   assign reload = rewind && (mode == MODE_REPLAY);

   assert_mark_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_hold && mode == MODE_NORMAL) |=> (mode == MODE_REPLAY && mark_ptr == $past(rd_ptr)));
   assert_mode_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mark_hold |=> (mode == MODE_NORMAL));
   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_hold && mode == MODE_REPLAY) |=> (mode == MODE_REPLAY && $stable(mark_ptr)));
endmodule

// File: rtl/mrf_ptr_ctrl.sv
module mrf_ptr_ctrl #(
   parameter int DEPTH = 8,
   parameter int PW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic          reload,
   input  logic          in_replay,
   input  logic [PW-1:0] mark_ptr,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] rd_ptr,
   output logic          do_wr,
   output logic          do_rd,
   output logic          empty,
   output logic          full
);
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

   logic [PW-1:0] base_ptr;
   logic [PW-1:0] span;
   logic [PW-1:0] occupancy;

   assign base_ptr  = in_replay ? mark_ptr : rd_ptr;
   assign span      = wr_ptr - base_ptr;
   assign occupancy = wr_ptr - rd_ptr;
   assign empty     = (occupancy == '0);
   assign full      = (span == DEPTH_P);
   assign do_wr     = wr_en && !full;
   assign do_rd     = rd_en && !empty && !reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
      end else if (do_wr) begin
         wr_ptr <= wr_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
      end else if (reload) begin
         rd_ptr <= mark_ptr;
      end else if (do_rd) begin
         rd_ptr <= rd_ptr + 1'b1;
      end
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> $stable(wr_ptr));
   assert_occupancy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      occupancy <= DEPTH_P);
   assert_mark_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_replay |-> ((wr_ptr - mark_ptr) <= DEPTH_P));
   assert_rewind_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (rd_ptr == $past(mark_ptr)));
   assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !reload) |=> $stable(rd_ptr));
endmodule

// File: rtl/mrf_store.sv
module mrf_store #(
   parameter int WIDTH      = 8,
   parameter int DEPTH      = 8,
   parameter int AW         = 3,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_wr,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             do_rd,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (do_wr) begin
         cells[wr_addr] <= wr_data;
      end
   end

   generate
      if (RESET_DATA) begin : g_rst_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_data <= '0;
            end else if (do_rd) begin
               rd_data <= cells[rd_addr];
            end
         end
      end else begin : g_raw_out
         always_ff @(posedge clk) begin
            if (do_rd) begin
               rd_data <= cells[rd_addr];
            end
         end
      end
   endgenerate

   assert_hold_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !do_rd |=> $stable(rd_data));
endmodule

// File: rtl/mark_rexmit_fifo.sv
module mark_rexmit_fifo
   import fifo_rt_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter int DEPTH      = 8,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   input  logic             mark_hold,
   input  logic             rewind,
   output logic             empty,
   output logic             full,
   output logic             replay_mode
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be a power of two and at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("WIDTH must be at least 1");
      end
   endgenerate

   fifo_mode_e    mode;
   logic [PW-1:0] mark_ptr;
   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;
   logic          reload;
   logic          do_wr;
   logic          do_rd;

   assign replay_mode = (mode == MODE_REPLAY);

   mrf_mark_ctrl #(.PW(PW)) u_mark (
      .clk       (clk),
      .rst_n     (rst_n),
      .mark_hold (mark_hold),
      .rewind    (rewind),
      .rd_ptr    (rd_ptr),
      .mode      (mode),
      .mark_ptr  (mark_ptr),
      .reload    (reload)
   );

   mrf_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .reload    (reload),
      .in_replay (replay_mode),
      .mark_ptr  (mark_ptr),
      .wr_ptr    (wr_ptr),
      .rd_ptr    (rd_ptr),
      .do_wr     (do_wr),
      .do_rd     (do_rd),
      .empty     (empty),
      .full      (full)
   );

   mrf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW), .RESET_DATA(RESET_DATA)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .do_wr   (do_wr),
      .wr_addr (wr_ptr[AW-1:0]),
      .wr_data (wr_data),
      .do_rd   (do_rd),
      .rd_addr (rd_ptr[AW-1:0]),
      .rd_data (rd_data)
   );

   assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full && !replay_mode));
   assert_replay_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full) |=> !empty || $past(rd_en) || $past(rewind));
endmodule

// File: tb/mark_rexmit_fifo_test.sv
module mark_rexmit_fifo_test;
   localparam int CLK_PERIOD = 10;
   localparam int WIDTH = 8;
   localparam int DEPTH = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [WIDTH-1:0] wr_data = '0;
   logic             rd_en = 1'b0;
   logic [WIDTH-1:0] rd_data;
   logic             mark_hold = 1'b0;
   logic             rewind = 1'b0;
   logic             empty, full, replay_mode;

   int n_checks = 0;
   int n_fails = 0;
   bit done = 0;

   // reference model state
   logic [WIDTH-1:0] m_mem [DEPTH];
   int m_wr = 0, m_rd = 0, m_mark = 0;
   bit m_mode = 0;
   logic [WIDTH-1:0] m_q = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mark_rexmit_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .mark_hold(mark_hold),
      .rewind(rewind), .empty(empty), .full(full), .replay_mode(replay_mode)
   );

   function automatic bit exp_empty();
      return m_wr == m_rd;
   endfunction

   function automatic bit exp_full();
      return (m_wr - (m_mode ? m_mark : m_rd)) == DEPTH;
   endfunction

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "empty", int'(empty), int'(exp_empty()));
      chk(req, "full", int'(full), int'(exp_full()));
      chk(req, "replay_mode", int'(replay_mode), int'(m_mode));
      chk(req, "rd_data", int'(rd_data), int'(m_q));
   endtask

   // model one clock edge from pre-edge state
   task automatic model_edge(input bit w, input logic [WIDTH-1:0] d, input bit r,
                             input bit mk, input bit rx);
      bit f = exp_full();
      bit e = exp_empty();
      int n_rd = m_rd;
      if (rx && m_mode) n_rd = m_mark;
      else if (r && !e) begin
         m_q = m_mem[m_rd % DEPTH];
         n_rd = m_rd + 1;
      end
      if (w && !f) begin
         m_mem[m_wr % DEPTH] = d;
         m_wr++;
      end
      if (!mk) m_mode = 0;
      else if (!m_mode) begin
         m_mode = 1;
         m_mark = m_rd;
      end
      m_rd = n_rd;
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input bit w, input logic [WIDTH-1:0] d, input bit r,
                       input bit mk, input bit rx, input string req);
      wr_en = w; wr_data = d; rd_en = r; mark_hold = mk; rewind = rx;
      @(posedge clk);
      model_edge(w, d, r, mk, rx);
      @(negedge clk);
      chk_all(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      bit mk;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "empty", int'(empty), 1);
      chk("R1", "full", int'(full), 0);
      chk("R1", "replay_mode", int'(replay_mode), 0);
      chk("R1", "rd_data", int'(rd_data), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 ordering
      for (int i = 0; i < 3; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, "R2");
      for (int i = 0; i < 3; i++) begin
         step(0, 0, 1, 0, 0, "R2");
         chk("R2", "read word", int'(rd_data), 16 + i);
      end
      // R4 read on empty
      step(0, 0, 1, 0, 0, "R4");
      chk("R4", "rd_data hold", int'(rd_data), 8'h12);
      // R3 overflow
      for (int i = 0; i < DEPTH; i++) step(1, 8'h20 + 8'(i), 0, 0, 0, "R3");
      chk("R3", "full", int'(full), 1);
      step(1, 8'hEE, 0, 0, 0, "R3");
      for (int i = 0; i < DEPTH; i++) begin
         step(0, 0, 1, 0, 0, "R3");
         chk("R3", "read word", int'(rd_data), 32 + i);
      end
      chk("R3", "empty after drain", int'(empty), 1);

      // R5 mark capture
      for (int i = 0; i < 4; i++) step(1, 8'h40 + 8'(i), 0, 0, 0, "R11");
      step(0, 0, 1, 0, 0, "R2");
      step(0, 0, 1, 1, 0, "R5");
      chk("R5", "replay_mode", int'(replay_mode), 1);
      step(0, 0, 1, 1, 0, "R6");
      // R11 writes in mode until the mark limit
      for (int i = 0; i < 5; i++) step(1, 8'h50 + 8'(i), 0, 1, 0, "R11");
      // R7 full at mark with occupancy below depth
      chk("R7", "full", int'(full), 1);
      chk("R7", "empty", int'(empty), 0);
      step(1, 8'hEE, 0, 1, 0, "R7");
      // R8 rewind and replay from marked word 0x41
      step(0, 0, 1, 1, 1, "R8");
      chk("R8", "full after rewind", int'(full), 1);
      for (int i = 0; i < 8; i++) begin
         step(0, 0, 1, 1, 0, "R8");
         chk("R8", "replayed word", int'(rd_data), (i < 3) ? 8'h41 + i : 8'h50 + (i - 3));
      end
      chk("R8", "empty", int'(empty), 1);
      // R6 exit and R10 release
      step(0, 0, 0, 0, 0, "R6");
      chk("R6", "replay_mode", int'(replay_mode), 0);
      chk("R10", "full", int'(full), 0);
      // R9 rewind outside mode
      step(1, 8'h66, 0, 0, 1, "R9");
      step(0, 0, 1, 0, 1, "R9");
      chk("R9", "read after ignored rewind", int'(rd_data), 8'h66);
      // R6 re-mark at a new place
      step(1, 8'h70, 0, 0, 0, "R6");
      step(1, 8'h71, 0, 1, 0, "R6");
      step(0, 0, 1, 1, 0, "R6");
      step(0, 0, 1, 1, 1, "R6");
      step(0, 0, 1, 1, 0, "R6");
      chk("R6", "new mark word", int'(rd_data), 8'h70);
      step(0, 0, 0, 0, 0, "R6");

      // random phase
      mk = 0;
      for (int i = 0; i < 6000; i++) begin
         if (($urandom % 16) == 0) mk = !mk;
         step(($urandom % 3) != 0, 8'($urandom), ($urandom % 2) == 0, mk,
              ($urandom % 12) == 0, "R2");
      end
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule